// File: doc/BRIEF.md
# Hardware Breakpoint Unit

This unit watches the CPU address bus and stops the program at a chosen instruction. Software loads a 16-bit target address into two byte registers and sets an enable bit. The next opcode fetch from that address raises a break request in the same cycle, so the CPU can put a software-interrupt opcode in place of the fetched one. The unit also gives the CPU the vector address to use. Software can raise the same request by writing 1 to the active flag; the CPU then takes it at the next instruction boundary.

The break state starts when the CPU acknowledges the request and ends with the return-from-interrupt pulse. While it lasts, the unit freezes the timers and decides whether peripheral status flags may be cleared. It also gates the watchdog when the test-voltage qualifier is high. Each hardware match consumes the target. Clearing the flag does not re-arm the unit; rewriting either address byte does. If the flag is still set when the routine returns, a new break follows.

Top module: `brk_match_unit`

## Requirements
- R1: After reset every register reads 0, brk_req, freeze and wdog_gate are 0, and flag_clr_en is 1.
- R2: Register offsets are 0 = control (bit 7 match enable, bit 6 active flag), 1 = target high byte, 2 = target low byte, and 3 = flag control (bit 7 clear-enable). Bits not listed read 0.
- R3: When the unit is enabled and armed, an opcode fetch (op_fetch=1) whose address equals the target raises brk_req in the same cycle. From the next cycle, control bit 6 reads 1.
- R4: A fetch with op_fetch=0, a fetch from any other address, or a fetch while enable is 0 does not raise brk_req.
- R5: A hardware match disarms the unit. Later matches on the same address do nothing until software writes offset 1 or 2.
- R6: Writing 1 to the active flag raises brk_req only while insn_boundary is 1.
- R7: brk_ack during brk_req sets freeze from the next cycle. rti_done clears freeze from the next cycle. brk_req stays 0 while freeze is 1.
- R8: vec_addr is 16'hFFFC, or 16'hFEFC while monitor_mode is 1.
- R9: flag_clr_en is 1 outside the break state. Inside it, flag_clr_en equals the clear-enable bit.
- R10: wdog_gate is 1 exactly when freeze and test_volt are both 1.
- R11: If the active flag is still 1 when the routine returns, brk_req rises again at the next instruction boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| cpu_addr | input | 16 | CPU address bus |
| op_fetch | input | 1 | Current bus cycle is an opcode fetch |
| insn_boundary | input | 1 | Next instruction is about to start |
| brk_ack | input | 1 | CPU accepts the break request |
| rti_done | input | 1 | Break routine returned |
| monitor_mode | input | 1 | Selects the monitor vector |
| test_volt | input | 1 | Test-voltage qualifier from the reset pin |
| brk_req | output | 1 | Break request to the CPU |
| vec_addr | output | 16 | Vector address to fetch |
| freeze | output | 1 | Stops the timer counters |
| flag_clr_en | output | 1 | Peripheral status flags may be cleared |
| wdog_gate | output | 1 | Disables the watchdog |

## Verification
brk_req, vec_addr, flag_clr_en, wdog_gate and read data depend combinationally on the inputs. The bench checks them 1 ns after driving on the falling edge. Register writes, the active flag set by a match, and freeze take effect at the next rising edge. They are checked on the falling edge that follows, one cycle after the stimulus. The address sweep toggles each bus bit against several targets. It checks that only the exact opcode-fetch match requests a break.

// File: rtl/brk_match_unit.sv
module brk_match_unit #(
  parameter int AW = 16,
  parameter logic [AW-1:0] VEC_NORMAL  = 16'hFFFC,
  parameter logic [AW-1:0] VEC_MONITOR = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [AW-1:0] cpu_addr,
  input  logic          op_fetch,
  input  logic          insn_boundary,
  input  logic          brk_ack,
  input  logic          rti_done,
  input  logic          monitor_mode,
  input  logic          test_volt,
  output logic          brk_req,
  output logic [AW-1:0] vec_addr,
  output logic          freeze,
  output logic          flag_clr_en,
  output logic          wdog_gate
);
  logic [7:0] tgt_hi, tgt_lo;
  logic en_q, flag_q, clr_q, armed_q, in_brk_q;
  logic hit_now;

  assign hit_now = en_q & armed_q & op_fetch & ~in_brk_q & (cpu_addr == {tgt_hi, tgt_lo});
  assign brk_req = ~in_brk_q & (hit_now | (flag_q & insn_boundary));
  assign vec_addr = monitor_mode ? VEC_MONITOR : VEC_NORMAL;
  assign freeze = in_brk_q;
  assign flag_clr_en = ~in_brk_q | clr_q;
  assign wdog_gate = in_brk_q & test_volt;

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = {en_q, flag_q, 6'b0};
      2'd1: reg_rdata = tgt_hi;
      2'd2: reg_rdata = tgt_lo;
      default: reg_rdata = {clr_q, 7'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_hi <= '0; tgt_lo <= '0;
      en_q <= 1'b0; flag_q <= 1'b0; clr_q <= 1'b0;
      armed_q <= 1'b0; in_brk_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          2'd0: begin en_q <= reg_wdata[7]; flag_q <= reg_wdata[6]; end
          2'd1: begin tgt_hi <= reg_wdata; armed_q <= 1'b1; end
          2'd2: begin tgt_lo <= reg_wdata; armed_q <= 1'b1; end
          default: clr_q <= reg_wdata[7];
        endcase
      end
      if (hit_now) begin
        flag_q <= 1'b1;
        armed_q <= 1'b0;
      end
      if (rti_done) in_brk_q <= 1'b0;
      else if (brk_ack && brk_req) in_brk_q <= 1'b1;
    end
  end

  // R3
  hit_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) hit_now |=> flag_q);
  // R5
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n) hit_now |=> !hit_now);
  // R7
  enter_brk_chk: assert property (@(posedge clk) disable iff (!rst_n) (brk_req && brk_ack && !rti_done) |=> freeze);
  // R7
  leave_brk_chk: assert property (@(posedge clk) disable iff (!rst_n) rti_done |=> !freeze);
  // R7
  quiet_req_chk: assert property (@(posedge clk) disable iff (!rst_n) freeze |-> !brk_req);
  // R9
  clr_open_chk: assert property (@(posedge clk) disable iff (!rst_n) !freeze |-> flag_clr_en);
  // R10
  wdog_in_brk_chk: assert property (@(posedge clk) disable iff (!rst_n) wdog_gate |-> freeze);
endmodule

// File: tb/brk_match_unit_test.sv
module brk_match_unit_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0; logic [1:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic [15:0] cpu_addr = 0;
  logic op_fetch = 0, insn_boundary = 0, brk_ack = 0, rti_done = 0, monitor_mode = 0, test_volt = 0;
  logic brk_req, freeze, flag_clr_en, wdog_gate;
  logic [15:0] vec_addr;
  int total = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  brk_match_unit uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_addr(cpu_addr), .op_fetch(op_fetch),
    .insn_boundary(insn_boundary), .brk_ack(brk_ack), .rti_done(rti_done),
    .monitor_mode(monitor_mode), .test_volt(test_volt), .brk_req(brk_req), .vec_addr(vec_addr),
    .freeze(freeze), .flag_clr_en(flag_clr_en), .wdog_gate(wdog_gate));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a; #1; chk(req, {8'h0, reg_rdata}, {8'h0, exp});
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] tgt;
    #22 rst_n = 1;
    @(negedge clk); #1;
    for (int a = 0; a < 4; a++) rd("R1", 2'(a), 8'h00);
    chk("R1", {15'h0, brk_req}, 0); chk("R1", {15'h0, freeze}, 0);
    chk("R1", {15'h0, flag_clr_en}, 1); chk("R1", {15'h0, wdog_gate}, 0);
    chk("R8", vec_addr, 16'hFFFC);

    wr(1, 8'hA5); rd("R2", 1, 8'hA5);
    wr(2, 8'h5A); rd("R2", 2, 8'h5A);
    wr(0, 8'hFF); rd("R2", 0, 8'hC0);
    wr(3, 8'hFF); rd("R2", 3, 8'h80);
    wr(3, 8'h00); wr(0, 8'h00); rd("R2", 0, 8'h00);

    // R4: enable off, exact match ignored
    @(negedge clk); cpu_addr = 16'hA55A; op_fetch = 1; #1; chk("R4", {15'h0, brk_req}, 0);
    @(negedge clk); op_fetch = 0; #1; rd("R4", 0, 8'h00);

    for (int k = 0; k < 8; k++) begin
      tgt = 16'(16'h1357 * (k + 1)) ^ 16'(k << 12);
      wr(0, 8'h80); wr(1, tgt[15:8]); wr(2, tgt[7:0]);
      for (int b = 0; b < 16; b++) begin
        @(negedge clk); cpu_addr = tgt ^ 16'(1 << b); op_fetch = 1; #1;
        chk("R4", {15'h0, brk_req}, 0);
      end
      @(negedge clk); cpu_addr = tgt; op_fetch = 0; #1; chk("R4", {15'h0, brk_req}, 0);
      op_fetch = 1; #1; chk("R3", {15'h0, brk_req}, 1);
      @(negedge clk); op_fetch = 0; #1; rd("R3", 0, 8'hC0);
    end

    // R5: flag cleared, same target stays silent until re-written
    wr(0, 8'h80);
    @(negedge clk); op_fetch = 1; #1; chk("R5", {15'h0, brk_req}, 0);
    @(negedge clk); op_fetch = 0;
    wr(2, tgt[7:0]);
    @(negedge clk); op_fetch = 1; #1; chk("R5", {15'h0, brk_req}, 1);
    @(negedge clk); op_fetch = 0;
    wr(0, 8'h00);

    // R6: software break waits for the boundary
    wr(0, 8'h40); #1; chk("R6", {15'h0, brk_req}, 0);
    insn_boundary = 1; #1; chk("R6", {15'h0, brk_req}, 1);
    brk_ack = 1;
    @(negedge clk); brk_ack = 0; #1;
    chk("R7", {15'h0, freeze}, 1); chk("R7", {15'h0, brk_req}, 0);
    chk("R9", {15'h0, flag_clr_en}, 0);
    wr(3, 8'h80); #1; chk("R9", {15'h0, flag_clr_en}, 1);
    wr(3, 8'h00); #1; chk("R9", {15'h0, flag_clr_en}, 0);
    test_volt = 1; #1; chk("R10", {15'h0, wdog_gate}, 1);
    monitor_mode = 1; #1; chk("R8", vec_addr, 16'hFEFC);
    monitor_mode = 0;
    rti_done = 1;
    @(negedge clk); rti_done = 0; #1;
    chk("R7", {15'h0, freeze}, 0); chk("R10", {15'h0, wdog_gate}, 0);
    chk("R9", {15'h0, flag_clr_en}, 1);
    chk("R11", {15'h0, brk_req}, 1);
    test_volt = 0;
    brk_ack = 1;
    @(negedge clk); brk_ack = 0; insn_boundary = 0;
    wr(0, 8'h00);
    rti_done = 1;
    @(negedge clk); rti_done = 0; insn_boundary = 1; #1;
    chk("R11", {15'h0, brk_req}, 0); chk("R7", {15'h0, freeze}, 0);
    insn_boundary = 0;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule